// File: doc/BRIEF.md
# AUX Request Sequencer with Channel Acquire and Retry

This block runs a single DisplayPort AUX request for a host. The host gives a 4-bit command type, a 20-bit address, a payload size between 1 and 16 bytes and up to 16 bytes of write data, then pulses `start_i`. The sequencer first waits for the channel's busy indication to clear. It then requests ownership of the channel and waits for a grant, and checks that a sink is attached. Only after these steps does it drive a line engine, which handles the actual line coding, through a reset / request / done interface.

Every attempt starts with a one-cycle engine reset pulse, followed by a request that is held high until the engine reports completion. A reply carrying any error bit causes the attempt to be retried. Retries after the first attempt are separated by a configurable gap, and the number of attempts has a limit. Each waiting phase has its own timeout. All delays are counted in clock cycles, derived from a cycles-per-microsecond parameter, so a bench can make them short. When the request is finished, the block releases the channel and pulses `done_o` with one of four results. For a successful read, it also returns the received bytes, trimmed to the requested size.

Top module: `aux_txn_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `own_req_o`, `eng_rst_o` and `eng_req_o` are all 0, and `tx_buf_o` and `rd_data_o` are zero.
- R2: `own_req_o` stays low while `chan_busy_i` is high. If `chan_busy_i` is still high TMO_CYC cycles after start, the result is busy (code 1) and neither ownership nor the engine is requested.
- R3: Once the channel is idle, `own_req_o` is raised. If `own_gnt_i` does not arrive within TMO_CYC cycles, the result is busy (code 1), `own_req_o` is low and the engine was never requested.
- R4: If `sink_i` is low after the grant, the result is no-sink (code 2) and no engine request is issued.
- R5: `eng_len_o` carries size minus one in 4 bits, `eng_cmd_o` carries the 4-bit command type and `eng_addr_o` carries the 20-bit address. All three stay stable while a request is high.
- R6: Each attempt has exactly one one-cycle `eng_rst_o` pulse before its request. The first request follows the grant with no gap delay (fewer than GAP_CYC cycles).
- R7: Before every attempt after the first, `eng_req_o` stays low for at least GAP_CYC cycles.
- R8: An attempt succeeds when `eng_err_i` is all zero, giving result ok (code 0). A nonzero `eng_err_i` causes a retry. The total number of attempts is at most MAX_TRIES, after which the result is remote-error (code 3).
- R9: If no `eng_done_i` arrives within TMO_CYC cycles of a request, the transaction ends with remote-error (code 3) and no further attempt is made.
- R10: Command bit 0 selects read (1) or write (0). For a write, `tx_buf_o` holds bytes 0..size-1 of `wr_data_i`, with higher bytes zero, before the request. A read leaves `tx_buf_o` unchanged.
- R11: A successful read sets `rd_data_o` to bytes 0..size-1 of `eng_rx_i`, with higher bytes zero. Any other outcome leaves `rd_data_o` zero.
- R12: `done_o` is a one-cycle pulse. `own_req_o` is low while `done_o` is high, whatever the outcome. `done_o` rises in the cycle after the edge that samples a deciding `eng_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when not busy |
| cmd_i | input | 4 | Command type, bit 0 = read |
| addr_i | input | 20 | Target address |
| size_i | input | 5 | Payload size in bytes, 1..16 |
| wr_data_i | input | 128 | Write payload, byte 0 in bits 7:0 |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 ok, 1 busy, 2 no-sink, 3 remote-error |
| rd_data_o | output | 128 | Read payload after a successful read |
| chan_busy_i | input | 1 | Channel busy indication |
| own_req_o | output | 1 | Channel ownership request |
| own_gnt_i | input | 1 | Channel ownership grant |
| sink_i | input | 1 | Sink present |
| tx_buf_o | output | 128 | Transmit buffer to the line engine |
| eng_cmd_o | output | 4 | Command field to the engine |
| eng_addr_o | output | 20 | Address field to the engine |
| eng_len_o | output | 4 | Size minus one |
| eng_rst_o | output | 1 | Engine reset pulse |
| eng_req_o | output | 1 | Engine request, held until done |
| eng_done_i | input | 1 | Engine completion pulse |
| eng_err_i | input | 8 | Reply error bits, valid with done |
| eng_rx_i | input | 128 | Received bytes, valid with done |

## Verification
The `done_o` pulse is due exactly one cycle after the rising edge that samples a deciding `eng_done_i`. The bench records the cycle in which its engine model raises done and the cycle in which `done_o` is seen, and requires the difference to be one. Timeout outcomes are due after TMO_CYC cycles plus a few state cycles. For these, the bench checks the lower bound against the elapsed cycle count since start and uses a watchdog loop for the upper bound. Gaps and reset pulses are counted by a negedge monitor that tallies low cycles of `eng_req_o` and rising edges of `eng_rst_o`. Results, buffers and fields are all sampled on falling edges after `done_o`.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_BUSY   = 2'd1,
    RES_NOSINK = 2'd2,
    RES_REMOTE = 2'd3
  } aux_res_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT_IDLE,
    ST_WAIT_GNT,
    ST_CHK_SINK,
    ST_RST_ON,
    ST_RST_OFF,
    ST_GAP,
    ST_WAIT_DONE,
    ST_FINISH
  } aux_st_e;

endpackage

// File: rtl/aux_tmo_timer.sv
module aux_tmo_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [TMR_W-1:0] val_i,
  output logic             exp_o
);

  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? val_i : (cnt_q - TMR_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign exp_o = (cnt_q == '0);

endmodule

// File: rtl/aux_data_path.sv
module aux_data_path #(
  parameter int BUF_BYTES = 16,
  parameter int ADDR_W    = 20,
  parameter int CMD_W     = 4,
  parameter int LEN_W     = 4,
  parameter int SIZE_W    = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap_i,
  input  logic                   tx_load_i,
  input  logic                   rx_load_i,
  input  logic [CMD_W-1:0]       cmd_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [SIZE_W-1:0]      size_i,
  input  logic [BUF_BYTES*8-1:0] wr_data_i,
  input  logic [BUF_BYTES*8-1:0] eng_rx_i,
  output logic                   is_read_o,
  output logic [CMD_W-1:0]       eng_cmd_o,
  output logic [ADDR_W-1:0]      eng_addr_o,
  output logic [LEN_W-1:0]       eng_len_o,
  output logic [BUF_BYTES*8-1:0] tx_buf_o,
  output logic [BUF_BYTES*8-1:0] rd_data_o
);

  localparam int BUF_W = BUF_BYTES * 8;

  logic [CMD_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [BUF_W-1:0]  wdat_q;
  logic [BUF_W-1:0]  tx_q, tx_d;
  logic [BUF_W-1:0]  rd_q, rd_d;
  logic [LEN_W-1:0]  len_d;

  assign len_d = LEN_W'(size_i - SIZE_W'(1));

  // Per-byte keep mask: byte b survives when b <= size-1
  for (genvar b = 0; b < BUF_BYTES; b++) begin : g_byte
    logic keep;
    assign keep = (LEN_W'(b) <= len_q);
    assign tx_d[b*8 +: 8] = keep ? wdat_q[b*8 +: 8]   : 8'h00;
    assign rd_d[b*8 +: 8] = keep ? eng_rx_i[b*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      len_q  <= '0;
      wdat_q <= '0;
    end else if (cap_i) begin
      cmd_q  <= cmd_i;
      addr_q <= addr_i;
      len_q  <= len_d;
      wdat_q <= wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tx_q <= '0;
    else if (tx_load_i) tx_q <= tx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_q <= '0;
    else if (cap_i)     rd_q <= '0;
    else if (rx_load_i) rd_q <= rd_d;
  end

  assign is_read_o  = cmd_q[0];
  assign eng_cmd_o  = cmd_q;
  assign eng_addr_o = addr_q;
  assign eng_len_o  = len_q;
  assign tx_buf_o   = tx_q;
  assign rd_data_o  = rd_q;

endmodule

// File: rtl/aux_txn_fsm.sv
module aux_txn_fsm
  import aux_seq_pkg::*;
#(
  parameter int MAX_TRIES = 32,
  parameter int TMR_W     = 8,
  parameter int TMO_CYC   = 100,
  parameter int GAP_CYC   = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             is_read_i,
  input  logic             chan_busy_i,
  input  logic             own_gnt_i,
  input  logic             sink_i,
  input  logic             eng_done_i,
  input  logic             err_any_i,
  input  logic             tmr_exp_i,
  output logic             tmr_load_o,
  output logic [TMR_W-1:0] tmr_val_o,
  output logic             cap_o,
  output logic             tx_load_o,
  output logic             rx_load_o,
  output logic             own_req_o,
  output logic             eng_rst_o,
  output logic             eng_req_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       result_o
);

  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_TRIES - 1);
  localparam logic [TMR_W-1:0] TMO_VAL  = TMR_W'(TMO_CYC);
  localparam logic [TMR_W-1:0] GAP_VAL  = TMR_W'(GAP_CYC);

  aux_st_e          st_q, st_d;
  logic [TRY_W-1:0] try_q, try_d;
  aux_res_e         res_q, res_d;

  always_comb begin
    st_d       = st_q;
    try_d      = try_q;
    res_d      = res_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = TMO_VAL;
    cap_o      = 1'b0;
    tx_load_o  = 1'b0;
    rx_load_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d       = ST_WAIT_IDLE;
          try_d      = '0;
          cap_o      = 1'b1;
          tmr_load_o = 1'b1;
        end
      end
      ST_WAIT_IDLE: begin
        if (!chan_busy_i) begin
          st_d       = ST_WAIT_GNT;
          tmr_load_o = 1'b1;
        end else if (tmr_exp_i) begin
          res_d = RES_BUSY;
          st_d  = ST_FINISH;
        end
      end
      ST_WAIT_GNT: begin
        if (own_gnt_i) begin
          st_d = ST_CHK_SINK;
        end else if (tmr_exp_i) begin
          res_d = RES_BUSY;
          st_d  = ST_FINISH;
        end
      end
      ST_CHK_SINK: begin
        if (!sink_i) begin
          res_d = RES_NOSINK;
          st_d  = ST_FINISH;
        end else begin
          tx_load_o = !is_read_i;
          st_d      = ST_RST_ON;
        end
      end
      ST_RST_ON: st_d = ST_RST_OFF;
      ST_RST_OFF: begin
        tmr_load_o = 1'b1;
        if (try_q == '0) begin
          st_d = ST_WAIT_DONE;
        end else begin
          tmr_val_o = GAP_VAL;
          st_d      = ST_GAP;
        end
      end
      ST_GAP: begin
        if (tmr_exp_i) begin
          tmr_load_o = 1'b1;
          st_d       = ST_WAIT_DONE;
        end
      end
      ST_WAIT_DONE: begin
        if (eng_done_i) begin
          if (!err_any_i) begin
            res_d     = RES_OK;
            rx_load_o = is_read_i;
            st_d      = ST_FINISH;
          end else if (try_q == LAST_TRY) begin
            res_d = RES_REMOTE;
            st_d  = ST_FINISH;
          end else begin
            try_d = try_q + TRY_W'(1);
            st_d  = ST_RST_ON;
          end
        end else if (tmr_exp_i) begin
          res_d = RES_REMOTE;
          st_d  = ST_FINISH;
        end
      end
      ST_FINISH: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      try_q <= '0;
      res_q <= RES_OK;
    end else begin
      st_q  <= st_d;
      try_q <= try_d;
      res_q <= res_d;
    end
  end

  assign own_req_o = (st_q != ST_IDLE) && (st_q != ST_WAIT_IDLE) && (st_q != ST_FINISH);
  assign eng_rst_o = (st_q == ST_RST_ON);
  assign eng_req_o = (st_q == ST_WAIT_DONE);
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = (st_q == ST_FINISH);
  assign result_o  = res_q;

endmodule

// File: rtl/aux_txn_seq.sv
module aux_txn_seq #(
  parameter int CYC_PER_US = 100,
  parameter int TMO_US     = 1000,
  parameter int GAP_US     = 400,
  parameter int MAX_TRIES  = 32,
  parameter int BUF_BYTES  = 16,
  parameter int ADDR_W     = 20,
  parameter int CMD_W      = 4,
  parameter int ERR_W      = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [CMD_W-1:0]       cmd_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [$clog2(BUF_BYTES):0] size_i,
  input  logic [BUF_BYTES*8-1:0] wr_data_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [1:0]             result_o,
  output logic [BUF_BYTES*8-1:0] rd_data_o,
  input  logic                   chan_busy_i,
  output logic                   own_req_o,
  input  logic                   own_gnt_i,
  input  logic                   sink_i,
  output logic [BUF_BYTES*8-1:0] tx_buf_o,
  output logic [CMD_W-1:0]       eng_cmd_o,
  output logic [ADDR_W-1:0]      eng_addr_o,
  output logic [$clog2(BUF_BYTES)-1:0] eng_len_o,
  output logic                   eng_rst_o,
  output logic                   eng_req_o,
  input  logic                   eng_done_i,
  input  logic [ERR_W-1:0]       eng_err_i,
  input  logic [BUF_BYTES*8-1:0] eng_rx_i
);

  localparam int LEN_W   = $clog2(BUF_BYTES);
  localparam int SIZE_W  = LEN_W + 1;
  localparam int TMO_CYC = CYC_PER_US * TMO_US;
  localparam int GAP_CYC = CYC_PER_US * GAP_US;
  localparam int MAX_CYC = (TMO_CYC > GAP_CYC) ? TMO_CYC : GAP_CYC;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);

  logic             tmr_load, tmr_exp;
  logic [TMR_W-1:0] tmr_val;
  logic             cap, tx_load, rx_load, is_read;

  aux_tmo_timer #(.TMR_W(TMR_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .exp_o  (tmr_exp)
  );

  aux_txn_fsm #(
    .MAX_TRIES (MAX_TRIES),
    .TMR_W     (TMR_W),
    .TMO_CYC   (TMO_CYC),
    .GAP_CYC   (GAP_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .is_read_i   (is_read),
    .chan_busy_i (chan_busy_i),
    .own_gnt_i   (own_gnt_i),
    .sink_i      (sink_i),
    .eng_done_i  (eng_done_i),
    .err_any_i   (|eng_err_i),
    .tmr_exp_i   (tmr_exp),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .cap_o       (cap),
    .tx_load_o   (tx_load),
    .rx_load_o   (rx_load),
    .own_req_o   (own_req_o),
    .eng_rst_o   (eng_rst_o),
    .eng_req_o   (eng_req_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .result_o    (result_o)
  );

  aux_data_path #(
    .BUF_BYTES (BUF_BYTES),
    .ADDR_W    (ADDR_W),
    .CMD_W     (CMD_W),
    .LEN_W     (LEN_W),
    .SIZE_W    (SIZE_W)
  ) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_i      (cap),
    .tx_load_i  (tx_load),
    .rx_load_i  (rx_load),
    .cmd_i      (cmd_i),
    .addr_i     (addr_i),
    .size_i     (size_i),
    .wr_data_i  (wr_data_i),
    .eng_rx_i   (eng_rx_i),
    .is_read_o  (is_read),
    .eng_cmd_o  (eng_cmd_o),
    .eng_addr_o (eng_addr_o),
    .eng_len_o  (eng_len_o),
    .tx_buf_o   (tx_buf_o),
    .rd_data_o  (rd_data_o)
  );

endmodule

// File: rtl/aux_txn_seq_chk.sv
module aux_txn_seq_chk #(
  parameter int GAP_CYC   = 40,
  parameter int MAX_TRIES = 32,
  parameter int ADDR_W    = 20,
  parameter int CMD_W     = 4,
  parameter int LEN_W     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              chan_busy_i,
  input logic              own_req_o,
  input logic              eng_rst_o,
  input logic              eng_req_o,
  input logic [CMD_W-1:0]  eng_cmd_o,
  input logic [ADDR_W-1:0] eng_addr_o,
  input logic [LEN_W-1:0]  eng_len_o
);

  localparam int GW = $clog2(GAP_CYC + 2) + 1;
  localparam int AW = $clog2(MAX_TRIES + 2) + 1;

  logic          req_q, rst_seen_q;
  logic [GW-1:0] low_q;
  logic [AW-1:0] att_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q      <= 1'b0;
      rst_seen_q <= 1'b0;
      low_q      <= '0;
      att_q      <= '0;
    end else begin
      req_q <= eng_req_o;
      if (eng_rst_o)                  rst_seen_q <= 1'b1;
      else if (eng_req_o && !req_q)   rst_seen_q <= 1'b0;
      if (eng_req_o)                  low_q <= '0;
      else if (low_q != {GW{1'b1}})   low_q <= low_q + GW'(1);
      if (start_i && !busy_o)         att_q <= '0;
      else if (eng_req_o && !req_q && att_q != {AW{1'b1}}) att_q <= att_q + AW'(1);
    end
  end

  a_r2_own_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own_req_o) |-> !$past(chan_busy_i));

  a_r5_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req_o && $past(eng_req_o)) |->
      ($stable(eng_len_o) && $stable(eng_cmd_o) && $stable(eng_addr_o)));

  a_r6_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_rst_o) |=> !eng_rst_o);

  a_r6_rst_before_req: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req_o && !req_q) |-> rst_seen_q);

  a_r6_req_owned: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req_o |-> own_req_o);

  a_r7_retry_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req_o && !req_q && att_q != '0) |-> (low_q >= GW'(GAP_CYC)));

  a_r8_attempt_limit: assert property (@(posedge clk) disable iff (!rst_n)
    att_q <= AW'(MAX_TRIES));

  a_r12_release: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !own_req_o);

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

bind aux_txn_seq aux_txn_seq_chk #(
  .GAP_CYC   (GAP_CYC),
  .MAX_TRIES (MAX_TRIES),
  .ADDR_W    (ADDR_W),
  .CMD_W     (CMD_W),
  .LEN_W     (LEN_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .chan_busy_i (chan_busy_i),
  .own_req_o   (own_req_o),
  .eng_rst_o   (eng_rst_o),
  .eng_req_o   (eng_req_o),
  .eng_cmd_o   (eng_cmd_o),
  .eng_addr_o  (eng_addr_o),
  .eng_len_o   (eng_len_o)
);

// File: tb/aux_txn_seq_tb_top.sv
module aux_txn_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CPU  = 1;
  localparam int TMO  = 40;
  localparam int GAP  = 10;
  localparam int MAXT = 32;
  localparam int TMO_CYC = CPU * TMO;
  localparam int GAP_CYC = CPU * GAP;

  logic         clk, rst_n;
  logic         start_i;
  logic [3:0]   cmd_i;
  logic [19:0]  addr_i;
  logic [4:0]   size_i;
  logic [127:0] wr_data_i;
  logic         busy_o, done_o;
  logic [1:0]   result_o;
  logic [127:0] rd_data_o;
  logic         chan_busy_i, own_req_o, own_gnt_i, sink_i;
  logic [127:0] tx_buf_o;
  logic [3:0]   eng_cmd_o;
  logic [19:0]  eng_addr_o;
  logic [3:0]   eng_len_o;
  logic         eng_rst_o, eng_req_o, eng_done_i;
  logic [7:0]   eng_err_i;
  logic [127:0] eng_rx_i;

  aux_txn_seq #(
    .CYC_PER_US (CPU),
    .TMO_US     (TMO),
    .GAP_US     (GAP),
    .MAX_TRIES  (MAXT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i), .addr_i(addr_i),
    .size_i(size_i), .wr_data_i(wr_data_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .rd_data_o(rd_data_o), .chan_busy_i(chan_busy_i),
    .own_req_o(own_req_o), .own_gnt_i(own_gnt_i), .sink_i(sink_i),
    .tx_buf_o(tx_buf_o), .eng_cmd_o(eng_cmd_o), .eng_addr_o(eng_addr_o),
    .eng_len_o(eng_len_o), .eng_rst_o(eng_rst_o), .eng_req_o(eng_req_o),
    .eng_done_i(eng_done_i), .eng_err_i(eng_err_i), .eng_rx_i(eng_rx_i)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // bench configuration of the models
  bit     gnt_en, eng_hang;
  int     fail_n;
  int     cyc = 0;
  int     done_mark;
  // monitor results
  int     own_rises, req_total, req_txn, rst_txn, min_gap, low_run, first_lat, gcnt;
  // transaction results
  logic [1:0]   t_res;
  int           t_start_cyc, t_done_cyc;

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] keep_bytes(input logic [127:0] d, input int n);
    logic [127:0] r = '0;
    for (int b = 0; b < 16; b++) if (b < n) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  // grant and line engine model
  initial begin
    int lat = 0;
    int att = 0;
    bit prev_own = 0;
    own_gnt_i  = 0;
    eng_done_i = 0;
    eng_err_i  = '0;
    eng_rx_i   = '0;
    done_mark  = 0;
    forever begin
      @(negedge clk);
      own_gnt_i = gnt_en && own_req_o;
      if (own_req_o && !prev_own) att = 0;
      prev_own = own_req_o;
      if (eng_done_i) begin
        eng_done_i = 0;
        eng_err_i  = '0;
        lat = 0;
      end else if (eng_req_o && !eng_hang) begin
        if (lat == 3) begin
          eng_done_i = 1;
          eng_err_i  = (att < fail_n) ? 8'h10 : 8'h00;
          eng_rx_i   = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F ^ {4{32'(att)}};
          done_mark  = cyc;
          att++;
          lat = 0;
        end else lat++;
      end else lat = 0;
    end
  end

  // monitor
  initial begin
    bit po = 0, pq = 0, pr = 0;
    own_rises = 0; req_total = 0; req_txn = 0; rst_txn = 0;
    min_gap = 1000000; low_run = 0; first_lat = 0; gcnt = 0;
    forever begin
      @(negedge clk);
      if (own_req_o && !po) begin
        own_rises++; req_txn = 0; rst_txn = 0; min_gap = 1000000; gcnt = 0;
      end
      if (eng_rst_o && !pr) rst_txn++;
      if (eng_req_o && !pq) begin
        if (req_txn > 0 && low_run < min_gap) min_gap = low_run;
        if (req_txn == 0) first_lat = gcnt;
        req_txn++; req_total++;
      end
      if (own_gnt_i && req_txn == 0) gcnt++;
      if (eng_req_o) low_run = 0; else low_run++;
      po = own_req_o; pq = eng_req_o; pr = eng_rst_o;
    end
  end

  task automatic run_txn(input logic [3:0] c, input logic [19:0] a,
                         input logic [4:0] s, input logic [127:0] w);
    @(negedge clk);
    cmd_i = c; addr_i = a; size_i = s; wr_data_i = w;
    start_i = 1;
    t_start_cyc = cyc;
    @(negedge clk);
    start_i = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done_o) break;
      @(negedge clk);
    end
    t_done_cyc = cyc;
    t_res = result_o;
    check(done_o == 1'b1, "R12 done seen", 128'(done_o), 128'd1);
    check(own_req_o == 1'b0, "R12 released at done", 128'(own_req_o), 128'd0);
    @(negedge clk);
    check(done_o == 1'b0, "R12 done one cycle", 128'(done_o), 128'd0);
  endtask

  task automatic set_env(input bit cb, input bit g, input bit sk, input int fn, input bit hg);
    chan_busy_i = cb; gnt_en = g; sink_i = sk; fail_n = fn; eng_hang = hg;
  endtask

  task automatic t_reset;
    check(busy_o == 0 && done_o == 0, "R1 busy/done", {busy_o, done_o}, 0);
    check(own_req_o == 0 && eng_rst_o == 0 && eng_req_o == 0, "R1 channel outputs",
          {own_req_o, eng_rst_o, eng_req_o}, 0);
    check(tx_buf_o == 0 && rd_data_o == 0, "R1 buffers", tx_buf_o | rd_data_o, 0);
  endtask

  task automatic t_write_ok;
    logic [127:0] w = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    set_env(0, 1, 1, 0, 0);
    run_txn(4'h8, 20'h00100, 5'd5, w);
    check(t_res == 2'd0, "R8 write ok", 128'(t_res), 0);
    check(t_done_cyc - done_mark == 1, "R12 done latency", 128'(t_done_cyc - done_mark), 1);
    check(eng_len_o == 4'd4, "R5 len=size-1", 128'(eng_len_o), 4);
    check(eng_cmd_o == 4'h8 && eng_addr_o == 20'h00100, "R5 cmd/addr",
          {eng_cmd_o, eng_addr_o}, {4'h8, 20'h00100});
    check(tx_buf_o == keep_bytes(w, 5), "R10 tx buffer masked", tx_buf_o, keep_bytes(w, 5));
    check(req_txn == 1 && rst_txn == 1, "R6 one rst, one req", 128'(rst_txn*16 + req_txn), 17);
    check(first_lat < GAP_CYC, "R6 first attempt no gap", 128'(first_lat), GAP_CYC);
    check(rd_data_o == 0, "R11 write leaves rd zero", rd_data_o, 0);
  endtask

  task automatic t_read_ok(input int n);
    logic [127:0] prev_tx = tx_buf_o;
    logic [127:0] rx = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;
    set_env(0, 1, 1, 0, 0);
    run_txn(4'h9, 20'h00202, 5'(n), 128'hDEAD);
    check(t_res == 2'd0, "R8 read ok", 128'(t_res), 0);
    check(rd_data_o == keep_bytes(rx, n), "R11 read data masked", rd_data_o, keep_bytes(rx, n));
    check(tx_buf_o == prev_tx, "R10 read leaves tx", tx_buf_o, prev_tx);
    check(eng_len_o == 4'(n - 1), "R5 len read", 128'(eng_len_o), 128'(n - 1));
  endtask

  task automatic t_retry_ok;
    set_env(0, 1, 1, 3, 0);
    run_txn(4'h9, 20'h00300, 5'd2, 0);
    check(t_res == 2'd0, "R8 ok after retries", 128'(t_res), 0);
    check(req_txn == 4, "R8 attempts", 128'(req_txn), 4);
    check(rst_txn == 4, "R6 rst per attempt", 128'(rst_txn), 4);
    check(min_gap >= GAP_CYC, "R7 retry gap", 128'(min_gap), GAP_CYC);
  endtask

  task automatic t_all_fail;
    set_env(0, 1, 1, 1000, 0);
    run_txn(4'h9, 20'h00400, 5'd1, 0);
    check(t_res == 2'd3, "R8 remote after limit", 128'(t_res), 3);
    check(req_txn == MAXT, "R8 attempt count", 128'(req_txn), MAXT);
    check(rd_data_o == 0, "R11 failed read zero", rd_data_o, 0);
  endtask

  task automatic t_hang;
    set_env(0, 1, 1, 0, 1);
    run_txn(4'h8, 20'h00500, 5'd1, 1);
    check(t_res == 2'd3, "R9 request timeout", 128'(t_res), 3);
    check(req_txn == 1, "R9 no further attempt", 128'(req_txn), 1);
    check(t_done_cyc - t_start_cyc >= TMO_CYC, "R9 timeout length",
          128'(t_done_cyc - t_start_cyc), TMO_CYC);
  endtask

  task automatic t_chan_busy;
    int o0 = own_rises;
    int r0 = req_total;
    set_env(1, 1, 1, 0, 0);
    run_txn(4'h8, 20'h00600, 5'd1, 1);
    check(t_res == 2'd1, "R2 busy result", 128'(t_res), 1);
    check(own_rises == o0, "R2 no ownership request", 128'(own_rises - o0), 0);
    check(req_total == r0, "R2 no engine request", 128'(req_total - r0), 0);
    check(t_done_cyc - t_start_cyc >= TMO_CYC, "R2 wait length",
          128'(t_done_cyc - t_start_cyc), TMO_CYC);
    chan_busy_i = 0;
  endtask

  task automatic t_no_grant;
    int o0 = own_rises;
    int r0 = req_total;
    set_env(0, 0, 1, 0, 0);
    run_txn(4'h8, 20'h00700, 5'd1, 1);
    check(t_res == 2'd1, "R3 busy on no grant", 128'(t_res), 1);
    check(own_rises == o0 + 1, "R3 ownership requested", 128'(own_rises - o0), 1);
    check(req_total == r0, "R3 no engine request", 128'(req_total - r0), 0);
  endtask

  task automatic t_no_sink;
    int r0 = req_total;
    set_env(0, 1, 0, 0, 0);
    run_txn(4'h8, 20'h00800, 5'd1, 1);
    check(t_res == 2'd2, "R4 no-sink result", 128'(t_res), 2);
    check(req_total == r0, "R4 no engine request", 128'(req_total - r0), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; cmd_i = 0; addr_i = 0; size_i = 1; wr_data_i = 0;
    set_env(0, 1, 1, 0, 0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_write_ok();
    t_read_ok(16);
    t_read_ok(3);
    t_retry_ok();
    t_all_fail();
    t_hang();
    t_chan_busy();
    t_no_grant();
    t_no_sink();
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule